// File: doc/BRIEF.md
# Strap-Selected Reference Clock Divider

This block divides an incoming reference clock by one of nine fixed ratios and emits a compare strobe one clock wide at the divided rate. That strobe feeds a downstream phase comparator, which expects an edge near 512 kHz. For example, a 16.384 MHz reference divided by 32 gives that rate, and so does a 17.92 MHz reference divided by 35. The ratio is picked by two board straps. Each strap can be tied low, tied high or left floating. Pad logic, outside this block, turns each strap into a 2-bit level code.

A run-time `bump` input raises the chosen ratio by one. This moves the comparison rate slightly, so that harmonic spurs can be pushed out of a sensitive band. A change to the straps or to `bump` is taken in only when the count wraps, so every divided period runs its full length. The ratio currently in force is reported on a status output. The strobe is also copied onto a second output that drives a test monitor.

Top module: `refdiv_strap_top`

## Requirements
- R1: With level codes 2'b00 = low, 2'b01 = floating and 2'b10 = high on `strap_a`/`strap_b`, the base ratio is as follows. For a high: b high → 32, b floating → 35, b low → 49. For a low: b high → 33, b floating → 36, b low → 48. For a floating: b high → 63, b low → 64, b floating → 65.
- R2: If either strap carries the code 2'b11, the base ratio is 32.
- R3: While `bump` is 1, the ratio applied is the base ratio plus one.
- R4: `cmp_strobe` is high for exactly one clock cycle. Consecutive strobes are spaced by exactly the ratio in force for that period.
- R5: A change on `strap_a`, `strap_b` or `bump` takes effect only at the clock edge that ends a strobe cycle. It never shortens or stretches the period in progress.
- R6: A synchronous active-high `rst` holds `cmp_strobe` low and `ratio_now` at 0. The first strobe after reset appears N cycles after the first clock edge at which `rst` is sampled low, where N is the ratio sampled at that edge.
- R7: `test_tap` is identical to `cmp_strobe` on every cycle.
- R8: `ratio_now` shows the ratio loaded for the current period and changes only at a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_a | input | 2 | First strap level code |
| strap_b | input | 2 | Second strap level code |
| bump | input | 1 | Adds one to the selected ratio |
| cmp_strobe | output | 1 | One-cycle strobe at the divided rate |
| test_tap | output | 1 | Copy of the strobe for test monitoring |
| ratio_now | output | 7 | Ratio in force for the current period |

## Verification
The embedded assertions check the following on every cycle:
- the strobe never lasts two cycles;
- the down-counter stays below the active ratio;
- the active ratio holds steady between reloads;
- each reload takes the ratio presented at that edge;
- the decoded ratio is always one of the legal values, or one of those plus one.

Some behaviour only the bench scenarios can show. These are the mapping of each strap pair to its specific ratio, the fallback for the illegal code, the added cycle from `bump`, the timing of the first strobe after reset, and the fact that changes made in mid-period are deferred. The bench checks these against an independent cycle model as the straps are swept and changed at arbitrary points.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int RATIO_W = 7;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_FLOAT = 2'b01,
        LVL_HIGH  = 2'b10,
        LVL_BAD   = 2'b11
    } strap_lvl_e;

    typedef struct packed {
        logic   armed;
        ratio_t remain;
        ratio_t active;
    } div_state_t;

    // Strap pair to base ratio; any illegal code selects 32.
    function automatic ratio_t base_ratio(strap_lvl_e a, strap_lvl_e b);
        ratio_t r;
        if (a == LVL_BAD || b == LVL_BAD) begin
            r = ratio_t'(32);
        end else begin
            unique case (a)
                LVL_LOW:   r = (b == LVL_HIGH) ? ratio_t'(33) : (b == LVL_FLOAT) ? ratio_t'(36) : ratio_t'(48);
                LVL_FLOAT: r = (b == LVL_HIGH) ? ratio_t'(63) : (b == LVL_FLOAT) ? ratio_t'(65) : ratio_t'(64);
                default:   r = (b == LVL_HIGH) ? ratio_t'(32) : (b == LVL_FLOAT) ? ratio_t'(35) : ratio_t'(49);
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/refdiv_select.sv
module refdiv_select
    import refdiv_pkg::*;
(
    input  logic [1:0] strap_a,
    input  logic [1:0] strap_b,
    input  logic       bump,
    output ratio_t     ratio_sel
);
    ratio_t base;

    always_comb begin
        base      = base_ratio(strap_lvl_e'(strap_a), strap_lvl_e'(strap_b));
        ratio_sel = base + ratio_t'(bump);
    end

    // R1 / R3: decoded value is always a legal ratio or a legal ratio plus one
    always_comb begin
        a_r1_legal_ratio: assert (ratio_sel inside {7'd32, 7'd33, 7'd34, 7'd35, 7'd36, 7'd37,
                                                    7'd48, 7'd49, 7'd50, 7'd63, 7'd64,
                                                    7'd65, 7'd66})
            else $error("ratio decode out of set");
    end
endmodule

// File: rtl/refdiv_core.sv
module refdiv_core
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t ratio_sel,
    output logic   strobe,
    output ratio_t ratio_act
);
    div_state_t st;
    logic       wrap;

    assign wrap      = st.armed && (st.remain == '0);
    assign strobe    = wrap;
    assign ratio_act = st.active;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (!st.armed || wrap) begin
            st.armed  <= 1'b1;
            st.remain <= ratio_sel - ratio_t'(1);
            st.active <= ratio_sel;
        end else begin
            st.remain <= st.remain - ratio_t'(1);
        end
    end

    a_r4_one_wide: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap)
        else $error("strobe wider than one cycle");

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        st.armed |-> (st.remain < st.active))
        else $error("counter outside active ratio");

    a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
        (st.armed && !wrap) |=> $stable(st.active))
        else $error("ratio changed mid-period");

    a_r5_reload_take: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (st.active == $past(ratio_sel)))
        else $error("reload did not take selected ratio");
endmodule

// File: rtl/refdiv_strap_top.sv
module refdiv_strap_top
    import refdiv_pkg::*;
#(
    parameter int RW = RATIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    strap_a,
    input  logic [1:0]    strap_b,
    input  logic          bump,
    output logic          cmp_strobe,
    output logic          test_tap,
    output logic [RW-1:0] ratio_now
);
    ratio_t sel_w;
    ratio_t act_w;
    logic   strobe_w;

    refdiv_select u_select (
        .strap_a   (strap_a),
        .strap_b   (strap_b),
        .bump      (bump),
        .ratio_sel (sel_w)
    );

    refdiv_core u_core (
        .clk       (clk),
        .rst       (rst),
        .ratio_sel (sel_w),
        .strobe    (strobe_w),
        .ratio_act (act_w)
    );

    assign cmp_strobe = strobe_w;
    assign test_tap   = strobe_w;
    assign ratio_now  = RW'(act_w);
endmodule

// File: tb/test_refdiv_strap_top.sv
module test_refdiv_strap_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sa = 2'b00;
    logic [1:0] sb = 2'b00;
    logic       bmp = 1'b0;
    logic       strobe, tap;
    logic [6:0] rnow;

    always #10 clk = ~clk;

    refdiv_strap_top i_refdiv_strap_top (
        .clk        (clk),
        .rst        (rst),
        .strap_a    (sa),
        .strap_b    (sb),
        .bump       (bmp),
        .cmp_strobe (strobe),
        .test_tap   (tap),
        .ratio_now  (rnow)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string tag    = "R6";
    bit    done   = 0;

    // Ratio table by index a*3+b with 0=low,1=floating,2=high
    function automatic int expect_ratio(logic [1:0] a, logic [1:0] b, logic p);
        int tbl [9] = '{48, 36, 33, 64, 65, 63, 49, 35, 32};
        if (a == 2'b11 || b == 2'b11) return 32 + int'(p);
        return tbl[int'(a) * 3 + int'(b)] + int'(p);
    endfunction

    // Behavioural timing model: absolute edge numbers of expected strobes
    longint edge_n  = 0;
    longint fire_at = -1;
    int     m_ratio = 0;
    bit     m_live  = 0;

    always @(posedge clk) begin
        edge_n++;
        if (rst) begin
            m_live  = 0;
            m_ratio = 0;
            fire_at = -1;
        end else if (!m_live || edge_n == fire_at + 1) begin
            m_live  = 1;
            m_ratio = expect_ratio(sa, sb, bmp);
            fire_at = edge_n + m_ratio - 1;
        end
    end

    task automatic chk(bit ok, string req, string what, int got, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %0d exp %0d at edge %0d", req, what, got, exp, edge_n);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            automatic int exp_s = (m_live && edge_n == fire_at) ? 1 : 0;
            chk(int'(strobe) == exp_s, tag, "cmp_strobe", int'(strobe), exp_s);
            chk(tap == strobe, "R7", "test_tap", int'(tap), int'(strobe));
            chk(int'(rnow) == m_ratio, "R8", "ratio_now", int'(rnow), m_ratio);
        end
    end

    task automatic run(int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        tag = "R6";
        run(4);
        rst = 1'b0;
        run(80);
        tag = "R1";
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                sa = 2'(a);
                sb = 2'(b);
                run(140);
            end
        end
        tag = "R3";
        bmp = 1'b1;
        sa = 2'b01; sb = 2'b01; run(200);
        sa = 2'b10; sb = 2'b10; run(120);
        bmp = 1'b0;
        run(100);
        tag = "R2";
        sa = 2'b11; sb = 2'b00; run(110);
        sa = 2'b00; sb = 2'b11; bmp = 1'b1; run(110);
        bmp = 1'b0;
        tag = "R5";
        for (int k = 0; k < 30; k++) begin
            sa  = 2'(k % 3);
            sb  = 2'((k * 2 + 1) % 3);
            bmp = k[0];
            run(13);
        end
        run(140);
        tag = "R6";
        sa = 2'b01; sb = 2'b10;
        rst = 1'b1; run(3);
        rst = 1'b0; run(150);
        tag = "R4";
        sa = 2'b10; sb = 2'b01; run(200);
        finish_up();
    end
endmodule